// File: doc/BRIEF.md
# Dual-Mode Serial Port with Transfer Queues

This block is a serial channel that can run either as a clocked synchronous port or as a start-bit framed asynchronous port. Software fills an eight-entry transmit queue, sets a byte count of one to eight, and issues a start pulse. The engine then moves that many bytes without further help and raises a one-cycle completion pulse that can serve as the interrupt. Bytes that arrive on the serial input are collected in a second eight-entry queue, which software drains with a pop strobe.

In synchronous mode the block drives its own serial clock with a period of sixteen system clocks. The output data changes on each falling clock edge, and the input is sampled on each rising edge. In asynchronous mode every byte is sent as one low start bit, eight data bits least significant first, and one high stop bit. A 2-bit rate field selects the bit length from a system-clock divider. An always-listening receiver finds start bits, samples each bit at its middle, and reports a bad stop bit.

Top module: `sio_fifo_port`

## Requirements
- R1: After reset so_o and sck_o are high, busy, done, underrun and frame_err are low, both queues are empty, and tx_full is low.
- R2: Each queue holds DEPTH (8) bytes. A tx_push while tx_full is high is dropped, and the queue keeps its first eight bytes in order. rx_rdata shows the oldest received byte while rx_empty is low.
- R3: In synchronous mode sck_o is low for SCK_HALF (8) clocks and then high for SCK_HALF clocks for each bit, giving a period of 16 clocks. so_o changes only when sck_o falls, and bits go out least significant first. Between transfers sck_o and so_o rest high.
- R4: In synchronous mode si_i is captured on the clock edge where sck_o rises. The eight captured bits form one byte, first bit as bit 0, which enters the receive queue at the end of that byte.
- R5: In asynchronous mode each byte is sent as a low start bit, then data bits 0 to 7, then a high stop bit, each lasting one bit period. The next start bit follows the stop bit with no gap, and sck_o stays high.
- R6: The bit period is BASE_DIV shifted left by rate_sel, so codes 0, 1, 2 and 3 give 1, 2, 4 and 8 times BASE_DIV clocks. The default of 1664 at 16 MHz gives 104 µs for code 0.
- R7: xfer_len_m1 holds the byte count minus one and is captured at start. Exactly that many bytes are sent. On the edge that ends the last bit, busy falls and done is high for exactly one cycle.
- R8: If the transmit queue is empty when the next byte is needed, including at start, the transfer stops and underrun is set and done pulses. underrun stays set until the next accepted start.
- R9: In asynchronous mode the receiver (after a two-flop synchronizer) takes a falling edge on si_i as a possible start bit. It checks that the line is still low half a bit later and then samples each data bit one bit period apart. A low pulse shorter than half a bit stores nothing and raises no error.
- R10: A stop bit sampled low sets frame_err and the byte is not stored. frame_err stays set until the next accepted start.
- R11: A start pulse while busy is high is ignored, including any change of xfer_len_m1.
- R12: A received byte that arrives while the receive queue is full is discarded, and the queued bytes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| async_mode | input | 1 | 0 = clocked synchronous, 1 = start-bit framed |
| rate_sel | input | 2 | Bit-period select for asynchronous mode |
| xfer_len_m1 | input | 3 | Bytes to send minus one |
| start | input | 1 | Begin an automatic transfer |
| tx_push | input | 1 | Write tx_wdata into the transmit queue |
| tx_wdata | input | 8 | Byte to queue |
| tx_full | output | 1 | Transmit queue holds eight bytes |
| tx_empty | output | 1 | Transmit queue is empty |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_rdata | output | 8 | Oldest received byte |
| rx_empty | output | 1 | Receive queue is empty |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| underrun | output | 1 | Transfer ended early on an empty queue |
| frame_err | output | 1 | A stop bit was received low |
| sck_o | output | 1 | Serial clock output |
| so_o | output | 1 | Serial data output |
| si_i | input | 1 | Serial data input |

## Verification
The properties assume that async_mode and rate_sel stay unchanged while busy is high, and that start, tx_push and rx_pop are synchronous single-clock strobes. The bench changes mode and rate only between transfers and drives all strobes half a cycle away from the active edge. It drives si_i only at points where the receiver or the synchronous sampler expects it. In loopback it ties si_i to so_o, so the receive path sees exactly the frames that the transmit path produces.

// File: rtl/sio_fifo_port.sv
module sio_fifo_port #(
  parameter int DW       = 8,
  parameter int DEPTH    = 8,
  parameter int SCK_HALF = 8,
  parameter int BASE_DIV = 1664
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     async_mode,
  input  logic [1:0]               rate_sel,
  input  logic [$clog2(DEPTH)-1:0] xfer_len_m1,
  input  logic                     start,
  input  logic                     tx_push,
  input  logic [DW-1:0]            tx_wdata,
  output logic                     tx_full,
  output logic                     tx_empty,
  input  logic                     rx_pop,
  output logic [DW-1:0]            rx_rdata,
  output logic                     rx_empty,
  output logic                     busy,
  output logic                     done,
  output logic                     underrun,
  output logic                     frame_err,
  output logic                     sck_o,
  output logic                     so_o,
  input  logic                     si_i
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int MAXT = (BASE_DIV * 8 > 2 * SCK_HALF) ? BASE_DIV * 8 : 2 * SCK_HALF;
  localparam int TW   = $clog2(MAXT + 1);
  localparam int BW   = $clog2(DW + 2);

  typedef enum logic [1:0] {E_IDLE, E_SYNC, E_ASYNC} eng_t;
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rcv_t;

  // transmit queue
  logic [DW-1:0] tmem [DEPTH];
  logic [AW-1:0] twp, trp;
  logic [CW-1:0] tcnt;
  logic          tpop;
  wire           tpush_ok = tx_push && !tx_full;

  assign tx_full  = tcnt == CW'(DEPTH);
  assign tx_empty = tcnt == '0;

  always_ff @(posedge clk) if (tpush_ok) tmem[twp] <= tx_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0;
    end else begin
      if (tpush_ok) twp <= (twp == AW'(DEPTH-1)) ? '0 : twp + AW'(1);
      if (tpop)     trp <= (trp == AW'(DEPTH-1)) ? '0 : trp + AW'(1);
      tcnt <= tcnt + CW'(tpush_ok) - CW'(tpop);
    end

  // receive queue
  logic [DW-1:0] rmem [DEPTH];
  logic [AW-1:0] rwp, rrp;
  logic [CW-1:0] rcnt;
  logic          rpush;
  logic [DW-1:0] rpush_data;
  wire           rpush_ok = rpush && (rcnt != CW'(DEPTH));
  wire           rpop_ok  = rx_pop && !rx_empty;

  assign rx_empty = rcnt == '0;
  assign rx_rdata = rmem[rrp];

  always_ff @(posedge clk) if (rpush_ok) rmem[rwp] <= rpush_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else begin
      if (rpush_ok) rwp <= (rwp == AW'(DEPTH-1)) ? '0 : rwp + AW'(1);
      if (rpop_ok)  rrp <= (rrp == AW'(DEPTH-1)) ? '0 : rrp + AW'(1);
      rcnt <= rcnt + CW'(rpush_ok) - CW'(rpop_ok);
    end

  // transmit engine
  eng_t          est;
  logic [TW-1:0] tick, tper;
  logic [BW-1:0] bitn;
  logic [AW-1:0] left;
  logic [DW-1:0] tsh, rsh;

  wire [TW-1:0] per_sel  = TW'(BASE_DIV) << rate_sel;
  wire          go       = (est == E_IDLE) && start;
  wire          byte_end = (est == E_SYNC  && tick == TW'(2*SCK_HALF-1) && bitn == BW'(DW-1)) ||
                           (est == E_ASYNC && tick == tper - TW'(1)     && bitn == BW'(DW+1));
  wire          want     = go || (byte_end && left != '0);
  wire          nxt_async = go ? async_mode : (est == E_ASYNC);
  wire [DW-1:0] head     = tmem[trp];

  assign tpop = want && !tx_empty;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      est <= E_IDLE; busy <= 1'b0; done <= 1'b0; underrun <= 1'b0;
      so_o <= 1'b1; sck_o <= 1'b1; tick <= '0; tper <= TW'(BASE_DIV);
      bitn <= '0; left <= '0; tsh <= '0; rsh <= '0;
    end else begin
      done <= 1'b0;
      if (go) underrun <= 1'b0;
      if (want) begin
        if (tx_empty) begin
          est <= E_IDLE; busy <= 1'b0; done <= 1'b1; underrun <= 1'b1;
          so_o <= 1'b1; sck_o <= 1'b1;
        end else begin
          busy <= 1'b1; tick <= '0; bitn <= '0; tsh <= head;
          if (go) begin
            tper <= per_sel;
            left <= xfer_len_m1;
            est  <= async_mode ? E_ASYNC : E_SYNC;
          end else begin
            left <= left - AW'(1);
          end
          if (nxt_async) so_o <= 1'b0;
          else begin
            sck_o <= 1'b0;
            so_o  <= head[0];
          end
        end
      end else if (byte_end) begin
        est <= E_IDLE; busy <= 1'b0; done <= 1'b1; so_o <= 1'b1; sck_o <= 1'b1;
      end else if (est == E_SYNC) begin
        if (tick == TW'(SCK_HALF-1)) begin
          sck_o <= 1'b1;
          rsh   <= {si_i, rsh[DW-1:1]};
          tick  <= tick + TW'(1);
        end else if (tick == TW'(2*SCK_HALF-1)) begin
          tick  <= '0;
          bitn  <= bitn + BW'(1);
          sck_o <= 1'b0;
          so_o  <= tsh[1];
          tsh   <= tsh >> 1;
        end else begin
          tick <= tick + TW'(1);
        end
      end else if (est == E_ASYNC) begin
        if (tick == tper - TW'(1)) begin
          tick <= '0;
          bitn <= bitn + BW'(1);
          if (bitn == '0) so_o <= tsh[0];
          else if (bitn < BW'(DW)) begin
            so_o <= tsh[1];
            tsh  <= tsh >> 1;
          end else so_o <= 1'b1;
        end else begin
          tick <= tick + TW'(1);
        end
      end
    end

  // asynchronous receiver
  logic          s1, s2, s3;
  rcv_t          rs;
  logic [TW-1:0] rtick;
  logic [BW-1:0] rbit;
  logic [DW-1:0] rdat;

  wire stop_pt  = (rs == R_STOP) && (rtick == per_sel - TW'(1));
  wire arx_push = stop_pt && s2;
  wire eng_push = byte_end && (est == E_SYNC);

  assign rpush      = eng_push || arx_push;
  assign rpush_data = eng_push ? rsh : rdat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      rs <= R_IDLE; rtick <= '0; rbit <= '0; rdat <= '0; frame_err <= 1'b0;
    end else begin
      s1 <= si_i; s2 <= s1; s3 <= s2;
      if (go) frame_err <= 1'b0;
      else if (stop_pt && !s2) frame_err <= 1'b1;
      if (!async_mode) rs <= R_IDLE;
      else case (rs)
        R_IDLE: if (s3 && !s2) begin rs <= R_START; rtick <= '0; end
        R_START:
          if (rtick == (per_sel >> 1) - TW'(1)) begin
            rtick <= '0; rbit <= '0;
            rs <= s2 ? R_IDLE : R_DATA;
          end else rtick <= rtick + TW'(1);
        R_DATA:
          if (rtick == per_sel - TW'(1)) begin
            rtick <= '0;
            rdat  <= {s2, rdat[DW-1:1]};
            rbit  <= rbit + BW'(1);
            if (rbit == BW'(DW-1)) rs <= R_STOP;
          end else rtick <= rtick + TW'(1);
        default:
          if (stop_pt) rs <= R_IDLE;
          else rtick <= rtick + TW'(1);
      endcase
    end
endmodule

module sio_fifo_port_chk (
  input logic clk,
  input logic rst_n,
  input logic async_mode,
  input logic start,
  input logic busy,
  input logic done,
  input logic underrun,
  input logic tx_full,
  input logic tx_empty,
  input logic sck_o,
  input logic so_o
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (sck_o && so_o));
  // R3
  so_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !async_mode && sck_o && $past(sck_o)) |-> $stable(so_o));
  // R5
  async_sck_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && async_mode) |-> sck_o);
  // R2
  queue_state_chk: assert property (@(posedge clk) disable iff (!rst_n) !(tx_full && tx_empty));
  // R8
  underrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !tx_empty) |=> !underrun);
endmodule

bind sio_fifo_port sio_fifo_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .start(start), .busy(busy),
  .done(done), .underrun(underrun), .tx_full(tx_full), .tx_empty(tx_empty),
  .sck_o(sck_o), .so_o(so_o)
);

// File: tb/tb_sio_fifo_port.sv
module tb_sio_fifo_port;
  localparam int BASE = 8;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0;
  logic async_mode = 0, start = 0, tx_push = 0, rx_pop = 0, si_drv = 1, loop = 0;
  logic [1:0] rate_sel = 0;
  logic [2:0] xfer_len_m1 = 0;
  logic [7:0] tx_wdata = 0, rx_rdata;
  logic tx_full, tx_empty, rx_empty, busy, done, underrun, frame_err, sck_o, so_o;
  wire  si_i = loop ? so_o : si_drv;

  always #4 clk = ~clk;

  sio_fifo_port #(.DW(8), .DEPTH(8), .SCK_HALF(HALF), .BASE_DIV(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .rate_sel(rate_sel),
    .xfer_len_m1(xfer_len_m1), .start(start), .tx_push(tx_push), .tx_wdata(tx_wdata),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_empty(rx_empty), .busy(busy), .done(done), .underrun(underrun),
    .frame_err(frame_err), .sck_o(sck_o), .so_o(so_o), .si_i(si_i));

  int checks = 0, errors = 0, seed = 1;
  bit chk_on = 0;
  string tag = "R3";
  logic exp_so = 1, exp_sck = 1, exp_busy = 0, exp_done = 0, exp_underrun = 0;
  logic [7:0] txq[$], rxq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // per-clock comparison against the reference model
  always @(negedge clk) if (chk_on) begin
    chk(so_o == exp_so, tag, so_o, exp_so);
    chk(sck_o == exp_sck, "R3", sck_o, exp_sck);
    chk(busy == exp_busy, "R7", busy, exp_busy);
    chk(done == exp_done, "R7", done, exp_done);
    chk(underrun == exp_underrun, "R8", underrun, exp_underrun);
    chk(tx_full == (txq.size() == 8), "R2", tx_full, txq.size() == 8);
  end

  task automatic push(input logic [7:0] d);
    @(negedge clk); tx_push = 1; tx_wdata = d;
    @(posedge clk); #1; tx_push = 0;
    if (txq.size() < 8) txq.push_back(d);
  endtask

  task automatic xfer(input bit md, input int sel, input int n, input bit poke);
    int t;
    logic [7:0] b, rb;
    t = BASE << sel;
    tag = md ? "R5" : "R3";
    @(negedge clk);
    async_mode = md; rate_sel = 2'(sel); xfer_len_m1 = 3'(n - 1); start = 1;
    @(posedge clk); #1; start = 0;
    exp_underrun = 0;
    for (int k = 0; k < n; k++) begin
      if (txq.size() == 0) begin exp_underrun = 1; break; end
      b = txq.pop_front(); exp_busy = 1;
      if (!md) begin
        rb = 8'(seed * 37 + 8'h5A); seed++;
        for (int i = 0; i < 8; i++) begin
          exp_sck = 0; exp_so = b[i]; si_drv = rb[i];
          repeat (HALF) @(posedge clk); #1; exp_sck = 1;
          repeat (HALF) @(posedge clk); #1;
        end
        if (rxq.size() < 8) rxq.push_back(rb);
      end else begin
        exp_so = 0; repeat (t) @(posedge clk); #1;
        for (int i = 0; i < 8; i++) begin
          exp_so = b[i];
          if (poke && k == 0 && i == 0) begin start = 1; xfer_len_m1 = 0; end // R11
          repeat (t) @(posedge clk); #1; start = 0;
        end
        exp_so = 1; repeat (t) @(posedge clk); #1;
        if (loop && rxq.size() < 8) rxq.push_back(b);
      end
    end
    exp_busy = 0; exp_done = 1; exp_so = 1; exp_sck = 1; si_drv = 1;
    @(posedge clk); #1; exp_done = 0;
  endtask

  task automatic drain(input string req);
    logic [7:0] e;
    repeat (12) @(posedge clk);
    while (rxq.size() > 0) begin
      e = rxq.pop_front();
      @(negedge clk);
      chk(!rx_empty, req, rx_empty, 0);
      chk(rx_rdata == e, req, rx_rdata, e);
      rx_pop = 1;
      @(negedge clk); rx_pop = 0;
    end
    @(negedge clk);
    chk(rx_empty, req, rx_empty, 1);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit good, input int sel);
    int t;
    t = BASE << sel;
    @(negedge clk); async_mode = 1; rate_sel = 2'(sel);
    repeat (4) @(posedge clk); #1;
    si_drv = 0; repeat (t) @(posedge clk); #1;
    for (int i = 0; i < 8; i++) begin si_drv = d[i]; repeat (t) @(posedge clk); #1; end
    si_drv = good; repeat (t) @(posedge clk); #1;
    si_drv = 1; repeat (2 * t) @(posedge clk);
    if (good && rxq.size() < 8) rxq.push_back(d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(so_o && sck_o, "R1", {so_o, sck_o}, 3);
    chk(!busy && !done && !underrun && !frame_err, "R1", {busy, done, underrun, frame_err}, 0);
    chk(rx_empty && tx_empty && !tx_full, "R1", {rx_empty, tx_empty, tx_full}, 6);
    chk_on = 1;

    // R2 nine pushes, the ninth dropped
    for (int i = 0; i < 9; i++) push(8'(8'h11 * (i + 1)));
    @(negedge clk); chk(tx_full, "R2", tx_full, 1);
    // R3 R4 R7 eight-byte synchronous transfer
    xfer(0, 0, 8, 0);
    // R12 ninth received byte dropped with the receive queue full
    push(8'hC3);
    xfer(0, 0, 1, 0);
    drain("R4");
    // R2 pop on an empty queue leaves it empty
    @(negedge clk); rx_pop = 1; @(negedge clk); rx_pop = 0;
    chk(rx_empty, "R2", rx_empty, 1);

    // R8 empty at start, then empty part way
    xfer(0, 0, 2, 0);
    push(8'h96); push(8'h3D);
    xfer(0, 0, 4, 0);
    drain("R8");

    // R5 R9 asynchronous loopback, rate codes 0 and 2, with a start while busy
    loop = 1;
    push(8'hA5); push(8'h01); push(8'hFE);
    xfer(1, 0, 3, 0);
    drain("R9");
    push(8'h5C); push(8'h80);
    xfer(1, 2, 2, 1); // R6 R11
    drain("R11");
    loop = 0;

    // R6 slowest rate
    push(8'h4B);
    xfer(1, 3, 1, 0);

    // R9 receive a frame at rate code 1, and ignore a short glitch
    send_frame(8'h6E, 1, 1);
    drain("R9");
    @(posedge clk); #1 si_drv = 0;
    repeat (2) @(posedge clk); #1 si_drv = 1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(rx_empty, "R9", rx_empty, 1);
    chk(!frame_err, "R9", frame_err, 0);

    // R10 bad stop bit
    send_frame(8'h33, 0, 1);
    @(negedge clk);
    chk(frame_err, "R10", frame_err, 1);
    chk(rx_empty, "R10", rx_empty, 1);
    xfer(1, 1, 1, 0);
    @(negedge clk);
    chk(!frame_err, "R10", frame_err, 0);

    repeat (5) @(posedge clk);
    finish_up();
  end
endmodule